// File: doc/BRIEF.md
# Transmit Descriptor Gather Engine

This block collects an outgoing frame from a chain of descriptors in system memory. Software points the engine at a descriptor, then writes the transmit control word with the DMA-enable bit set. The engine then walks the chain on its own memory master port. Each descriptor it owns names one buffer fragment. The engine copies that fragment into a local frame store of up to 2048 bytes and returns the descriptor to software by writing back its status word with the ownership bit cleared.

When a descriptor carries the end-of-frame flag, the engine streams the stored frame out as bytes on a valid/ready channel with a last marker. A checksum-offload request accompanies the frame. The engine waits until the whole frame has been accepted before it fetches the next descriptor. The walk stops at the first descriptor that software still holds, or at a fragment that would overflow the frame store. If at least one frame left the engine during the walk, it raises a sticky completion flag and drops the transfer-start bit.

Top module: `txd_gather`

## Requirements
- R1: After reset the engine is idle. busy_o, done_o, xfer_start_o, mem_req_o and tx_tvalid_o are all 0, and cur_desc_o is 0.
- R2: A pulse on list_wr_i while the engine is idle loads list_addr_i into the current-descriptor pointer (cur_desc_o), effective the next cycle. A pulse on list_wr_i while busy_o is 1 is ignored.
- R3: Every ctl_wr_i stores ctl_wdata_i[31] as the transfer-start bit, shown on xfer_start_o. A walk starts only when ctl_wdata_i[30] is 1 and the engine is idle. A write with bit 30 clear fetches nothing.
- R4: A descriptor is four 32-bit words at byte offsets 0 (status), 4 (control), 8 (buffer address) and 12 (next-descriptor address). The walk continues only while status bit 31 (owned) is 1. It stops with cur_desc_o holding the address of the first descriptor whose bit 31 is 0.
- R5: The fragment length is control bits 10:0, in bytes. The buffer address is word aligned. Bytes are taken from each 32-bit word starting with the least significant byte. A zero-length fragment contributes no bytes.
- R6: After a fragment is copied, the status word is written back to offset 0 with bit 31 cleared and every other bit unchanged.
- R7: Fragments accumulate until a descriptor has control bit 30 (end of frame) set. The stored bytes are then emitted in order on tx_tdata_o, with tx_tlast_o on the final byte only. The next frame starts empty. Control bit 29 (first) has no effect.
- R8: While tx_tvalid_o is 1 and tx_tready_i is 0, tx_tdata_o, tx_tlast_o and tx_csum_o hold their values. No memory request is made while a frame is being emitted.
- R9: tx_csum_o is 1 for every byte of a frame whose end-of-frame descriptor has a nonzero control field 28:27.
- R10: A fragment is rejected if the bytes already gathered for the frame plus its length exceed 2048. For a rejected fragment, the status is written back with bit 14 set and bit 31 still set. No byte of that frame is emitted, and the walk stops with cur_desc_o on that descriptor. A frame of exactly 2048 bytes is accepted.
- R11: When a walk ends and at least one frame was emitted, done_o becomes 1 and xfer_start_o becomes 0. If no frame was emitted, neither changes. done_o stays 1 until a done_clr_i pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| list_wr_i | input | 1 | Load the descriptor pointer |
| list_addr_i | input | 32 | Descriptor address to load |
| ctl_wr_i | input | 1 | Write of the transmit control word |
| ctl_wdata_i | input | 32 | Control word: bit 31 start, bit 30 DMA enable |
| done_clr_i | input | 1 | Clear the completion flag |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 for a write, 0 for a read |
| mem_addr_o | output | 32 | Byte address of the accessed word |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request completes this cycle |
| mem_rdata_i | input | 32 | Read data, valid with mem_ack_i |
| tx_tvalid_o | output | 1 | Frame byte valid |
| tx_tdata_o | output | 8 | Frame byte |
| tx_tlast_o | output | 1 | Final byte of the frame |
| tx_csum_o | output | 1 | Checksum-offload request for the frame |
| tx_tready_i | input | 1 | Downstream accepts the byte |
| cur_desc_o | output | 32 | Current descriptor pointer |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | Sticky transmit-complete flag |
| xfer_start_o | output | 1 | Transfer-start bit of the control word |

## Verification
The assertions check several rules on every cycle. Output bytes and the checksum flag stay stable under backpressure. The memory port is silent during emission and while idle. Every write goes to a status word, and it either hands the descriptor back or keeps ownership while flagging a length error. A pointer load and an enabled kick take effect as required, and completion coincides with a cleared start bit. Other behaviour can only be shown by the scenarios, which compare the data against descriptors built in a memory model. These cover byte order across fragments, empty fragments, chaining of several frames, and the exact 2048-byte boundary. They also cover the rejected-overflow path, the stop on an unowned descriptor, and a pointer write ignored mid-walk.

// File: rtl/tgx_pkg.sv
package tgx_pkg;

  localparam int WORD_W     = 32;
  localparam int FRAG_W     = 11;
  localparam int OWN_BIT    = 31;
  localparam int EOF_BIT    = 30;
  localparam int LENERR_BIT = 14;
  localparam int CSUM_HI    = 28;
  localparam int CSUM_LO    = 27;
  localparam int KICK_BIT   = 30;
  localparam int START_BIT  = 31;

  localparam int OFS_STAT = 0;
  localparam int OFS_CTL  = 4;
  localparam int OFS_BUF  = 8;
  localparam int OFS_NEXT = 12;

  typedef enum logic [3:0] {
    W_IDLE,
    W_RD_STAT,
    W_RD_CTL,
    W_RD_BUFP,
    W_RD_NEXT,
    W_RD_WORD,
    W_UNPACK,
    W_WB,
    W_WB_ERR,
    W_SEND,
    W_FINISH
  } walk_st_e;

endpackage

// File: rtl/tgx_store.sv
module tgx_store #(
  parameter int BUF_BYTES = 2048,
  localparam int IDX_W    = $clog2(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [7:0]       wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [7:0]       rdata_o
);

  logic [7:0] mem_q [BUF_BYTES];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/tgx_emit.sv
module tgx_emit #(
  parameter int BUF_BYTES = 2048,
  localparam int IDX_W    = $clog2(BUF_BYTES),
  localparam int CNT_W    = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             csum_i,
  output logic [IDX_W-1:0] rd_idx_o,
  input  logic [7:0]       rd_byte_i,
  output logic             tvalid_o,
  output logic [7:0]       tdata_o,
  output logic             tlast_o,
  output logic             tcsum_o,
  input  logic             tready_i,
  output logic             done_o
);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic             csum_q, csum_d;
  logic             fire;

  assign tvalid_o = busy_q;
  assign tdata_o  = rd_byte_i;
  assign tlast_o  = busy_q && (idx_q == len_q - CNT_W'(1));
  assign tcsum_o  = busy_q && csum_q;
  assign rd_idx_o = idx_q[IDX_W-1:0];
  assign fire     = busy_q && tready_i;
  assign done_o   = fire && tlast_o;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    len_d  = len_q;
    csum_d = csum_q;
    if (start_i && !busy_q) begin
      busy_d = 1'b1;
      idx_d  = '0;
      len_d  = len_i;
      csum_d = csum_i;
    end else if (fire) begin
      if (tlast_o) busy_d = 1'b0;
      else         idx_d  = idx_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      len_q  <= '0;
      csum_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      len_q  <= len_d;
      csum_q <= csum_d;
    end
  end

endmodule

// File: rtl/tgx_walker.sv
module tgx_walker
  import tgx_pkg::*;
#(
  parameter int AW        = 32,
  parameter int BUF_BYTES = 2048,
  localparam int IDX_W    = $clog2(BUF_BYTES),
  localparam int CNT_W    = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              list_wr_i,
  input  logic [AW-1:0]     list_addr_i,
  input  logic              ctl_wr_i,
  input  logic [WORD_W-1:0] ctl_wdata_i,
  input  logic              done_clr_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              bw_en_o,
  output logic [IDX_W-1:0]  bw_addr_o,
  output logic [7:0]        bw_data_o,
  output logic              frm_start_o,
  output logic [CNT_W-1:0]  frm_len_o,
  output logic              frm_csum_o,
  input  logic              frm_done_i,
  output logic [AW-1:0]     cur_desc_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              xfer_start_o
);

  walk_st_e          st_q, st_d;
  logic [AW-1:0]     cur_q, cur_d;
  logic [AW-1:0]     nxt_q, nxt_d;
  logic [AW-1:0]     bufp_q, bufp_d;
  logic [WORD_W-1:0] stat_q, stat_d;
  logic [WORD_W-1:0] dctl_q, dctl_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [FRAG_W-1:0] left_q, left_d;
  logic [1:0]        lane_q, lane_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              sent_q, sent_d;
  logic              start_q, start_d;
  logic              done_q, done_d;
  logic              ack;
  logic [CNT_W:0]    need;
  logic              kick;

  assign ack  = mem_req_o && mem_ack_i;
  assign kick = ctl_wr_i && ctl_wdata_i[KICK_BIT] && (st_q == W_IDLE);
  assign need = {1'b0, cnt_q} + (CNT_W+1)'(mem_rdata_i[FRAG_W-1:0]);

  // memory port decode
  always_comb begin
    mem_req_o   = 1'b1;
    mem_we_o    = 1'b0;
    mem_addr_o  = cur_q;
    mem_wdata_o = stat_q;
    unique case (st_q)
      W_RD_STAT: mem_addr_o = cur_q + AW'(OFS_STAT);
      W_RD_CTL:  mem_addr_o = cur_q + AW'(OFS_CTL);
      W_RD_BUFP: mem_addr_o = cur_q + AW'(OFS_BUF);
      W_RD_NEXT: mem_addr_o = cur_q + AW'(OFS_NEXT);
      W_RD_WORD: mem_addr_o = {bufp_q[AW-1:2], 2'b00};
      W_WB: begin
        mem_we_o             = 1'b1;
        mem_addr_o           = cur_q + AW'(OFS_STAT);
        mem_wdata_o[OWN_BIT] = 1'b0;
      end
      W_WB_ERR: begin
        mem_we_o                = 1'b1;
        mem_addr_o              = cur_q + AW'(OFS_STAT);
        mem_wdata_o[LENERR_BIT] = 1'b1;
      end
      default: mem_req_o = 1'b0;
    endcase
  end

  assign bw_en_o     = (st_q == W_UNPACK);
  assign bw_addr_o   = cnt_q[IDX_W-1:0];
  assign bw_data_o   = word_q[8*lane_q +: 8];
  assign frm_len_o   = cnt_q;
  assign frm_csum_o  = |dctl_q[CSUM_HI:CSUM_LO];
  assign frm_start_o = (st_q == W_WB) && ack && dctl_q[EOF_BIT] && (cnt_q != '0);

  // next state
  always_comb begin
    st_d    = st_q;
    cur_d   = cur_q;
    nxt_d   = nxt_q;
    bufp_d  = bufp_q;
    stat_d  = stat_q;
    dctl_d  = dctl_q;
    word_d  = word_q;
    left_d  = left_q;
    lane_d  = lane_q;
    cnt_d   = cnt_q;
    sent_d  = sent_q;
    start_d = ctl_wr_i ? ctl_wdata_i[START_BIT] : start_q;
    done_d  = done_q && !done_clr_i;

    unique case (st_q)
      W_IDLE: begin
        if (list_wr_i) cur_d = list_addr_i;
        if (kick) begin
          st_d   = W_RD_STAT;
          cnt_d  = '0;
          sent_d = 1'b0;
        end
      end
      W_RD_STAT: if (ack) begin
        stat_d = mem_rdata_i;
        st_d   = mem_rdata_i[OWN_BIT] ? W_RD_CTL : W_FINISH;
      end
      W_RD_CTL: if (ack) begin
        dctl_d = mem_rdata_i;
        st_d   = (need > (CNT_W+1)'(BUF_BYTES)) ? W_WB_ERR : W_RD_BUFP;
      end
      W_RD_BUFP: if (ack) begin
        bufp_d = mem_rdata_i[AW-1:0];
        left_d = dctl_q[FRAG_W-1:0];
        st_d   = W_RD_NEXT;
      end
      W_RD_NEXT: if (ack) begin
        nxt_d = mem_rdata_i[AW-1:0];
        st_d  = (left_q != '0) ? W_RD_WORD : W_WB;
      end
      W_RD_WORD: if (ack) begin
        word_d = mem_rdata_i;
        lane_d = 2'd0;
        st_d   = W_UNPACK;
      end
      W_UNPACK: begin
        cnt_d  = cnt_q + CNT_W'(1);
        left_d = left_q - FRAG_W'(1);
        lane_d = lane_q + 2'd1;
        if (left_q == FRAG_W'(1)) begin
          st_d = W_WB;
        end else if (lane_q == 2'd3) begin
          bufp_d = bufp_q + AW'(4);
          st_d   = W_RD_WORD;
        end
      end
      W_WB: if (ack) begin
        if (!dctl_q[EOF_BIT]) begin
          cur_d = nxt_q;
          st_d  = W_RD_STAT;
        end else if (cnt_q != '0) begin
          st_d = W_SEND;
        end else begin
          sent_d = 1'b1;
          cur_d  = nxt_q;
          st_d   = W_RD_STAT;
        end
      end
      W_SEND: if (frm_done_i) begin
        cnt_d  = '0;
        sent_d = 1'b1;
        cur_d  = nxt_q;
        st_d   = W_RD_STAT;
      end
      W_WB_ERR: if (ack) st_d = W_FINISH;
      W_FINISH: begin
        if (sent_q) begin
          done_d  = 1'b1;
          start_d = 1'b0;
        end
        sent_d = 1'b0;
        cnt_d  = '0;
        st_d   = W_IDLE;
      end
      default: st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= W_IDLE;
      cur_q   <= '0;
      nxt_q   <= '0;
      bufp_q  <= '0;
      stat_q  <= '0;
      dctl_q  <= '0;
      word_q  <= '0;
      left_q  <= '0;
      lane_q  <= '0;
      cnt_q   <= '0;
      sent_q  <= 1'b0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cur_q   <= cur_d;
      nxt_q   <= nxt_d;
      bufp_q  <= bufp_d;
      stat_q  <= stat_d;
      dctl_q  <= dctl_d;
      word_q  <= word_d;
      left_q  <= left_d;
      lane_q  <= lane_d;
      cnt_q   <= cnt_d;
      sent_q  <= sent_d;
      start_q <= start_d;
      done_q  <= done_d;
    end
  end

  assign cur_desc_o   = cur_q;
  assign busy_o       = (st_q != W_IDLE);
  assign done_o       = done_q;
  assign xfer_start_o = start_q;

endmodule

// File: rtl/txd_gather.sv
module txd_gather #(
  parameter int AW        = 32,
  parameter int BUF_BYTES = 2048,
  localparam int IDX_W    = $clog2(BUF_BYTES),
  localparam int CNT_W    = IDX_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          list_wr_i,
  input  logic [AW-1:0] list_addr_i,
  input  logic          ctl_wr_i,
  input  logic [31:0]   ctl_wdata_i,
  input  logic          done_clr_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          tx_tvalid_o,
  output logic [7:0]    tx_tdata_o,
  output logic          tx_tlast_o,
  output logic          tx_csum_o,
  input  logic          tx_tready_i,
  output logic [AW-1:0] cur_desc_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          xfer_start_o
);

  logic             bw_en;
  logic [IDX_W-1:0] bw_addr;
  logic [7:0]       bw_data;
  logic [IDX_W-1:0] rd_idx;
  logic [7:0]       rd_byte;
  logic             frm_start;
  logic [CNT_W-1:0] frm_len;
  logic             frm_csum;
  logic             frm_done;

  tgx_walker #(.AW(AW), .BUF_BYTES(BUF_BYTES)) u_walker (
    .clk          (clk),
    .rst_n        (rst_n),
    .list_wr_i    (list_wr_i),
    .list_addr_i  (list_addr_i),
    .ctl_wr_i     (ctl_wr_i),
    .ctl_wdata_i  (ctl_wdata_i),
    .done_clr_i   (done_clr_i),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_ack_i    (mem_ack_i),
    .mem_rdata_i  (mem_rdata_i),
    .bw_en_o      (bw_en),
    .bw_addr_o    (bw_addr),
    .bw_data_o    (bw_data),
    .frm_start_o  (frm_start),
    .frm_len_o    (frm_len),
    .frm_csum_o   (frm_csum),
    .frm_done_i   (frm_done),
    .cur_desc_o   (cur_desc_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .xfer_start_o (xfer_start_o)
  );

  tgx_store #(.BUF_BYTES(BUF_BYTES)) u_store (
    .clk     (clk),
    .we_i    (bw_en),
    .waddr_i (bw_addr),
    .wdata_i (bw_data),
    .raddr_i (rd_idx),
    .rdata_o (rd_byte)
  );

  tgx_emit #(.BUF_BYTES(BUF_BYTES)) u_emit (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (frm_start),
    .len_i     (frm_len),
    .csum_i    (frm_csum),
    .rd_idx_o  (rd_idx),
    .rd_byte_i (rd_byte),
    .tvalid_o  (tx_tvalid_o),
    .tdata_o   (tx_tdata_o),
    .tlast_o   (tx_tlast_o),
    .tcsum_o   (tx_csum_o),
    .tready_i  (tx_tready_i),
    .done_o    (frm_done)
  );

endmodule

// File: rtl/tgx_checker.sv
module tgx_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          list_wr_i,
  input logic [AW-1:0] list_addr_i,
  input logic          ctl_wr_i,
  input logic [31:0]   ctl_wdata_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_wdata_o,
  input logic          tx_tvalid_o,
  input logic [7:0]    tx_tdata_o,
  input logic          tx_tlast_o,
  input logic          tx_csum_o,
  input logic          tx_tready_i,
  input logic [AW-1:0] cur_desc_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          xfer_start_o
);

  p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tvalid_o && !tx_tready_i |=> tx_tvalid_o && $stable(tx_tdata_o) && $stable(tx_tlast_o));

  p_hold_csum_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tvalid_o && !tx_tready_i |=> $stable(tx_csum_o));

  p_quiet_emit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tvalid_o |-> !mem_req_o);

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o && !tx_tvalid_o);

  p_load_ptr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && list_wr_i |=> cur_desc_o == $past(list_addr_i));

  p_kick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && ctl_wr_i && ctl_wdata_i[30] |=> busy_o);

  p_wb_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o |-> mem_addr_o[3:0] == 4'h0);

  p_handback_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o && !mem_wdata_o[14] |-> !mem_wdata_o[31]);

  p_err_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o && mem_wdata_o[14] |-> mem_wdata_o[31]);

  p_done_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> !xfer_start_o);

endmodule

bind txd_gather tgx_checker #(.AW(AW)) u_tgx_checker (.*);

// File: tb/test_txd_gather.sv
`timescale 1ns/1ps
module test_txd_gather;

  logic        clk;
  logic        rst_n;
  logic        list_wr_i;
  logic [31:0] list_addr_i;
  logic        ctl_wr_i;
  logic [31:0] ctl_wdata_i;
  logic        done_clr_i;
  logic        mem_req_o;
  logic        mem_we_o;
  logic [31:0] mem_addr_o;
  logic [31:0] mem_wdata_o;
  logic        mem_ack_i;
  logic [31:0] mem_rdata_i;
  logic        tx_tvalid_o;
  logic [7:0]  tx_tdata_o;
  logic        tx_tlast_o;
  logic        tx_csum_o;
  logic        tx_tready_i;
  logic [31:0] cur_desc_o;
  logic        busy_o;
  logic        done_o;
  logic        xfer_start_o;

  txd_gather i_txd_gather (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  logic [31:0] wmem [0:4095];
  logic [9:0]  exp_q [$];
  logic [15:0] lfsr;

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: one access per two cycles
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack_i = 1'b0;
    end else if (mem_ack_i) begin
      mem_ack_i = 1'b0;
    end else if (mem_req_o) begin
      if (mem_we_o) wmem[mem_addr_o[13:2]] = mem_wdata_o;
      else          mem_rdata_i = wmem[mem_addr_o[13:2]];
      mem_ack_i = 1'b1;
    end
  end

  // scoreboard monitor and backpressure
  always @(negedge clk) begin
    if (rst_n && tx_tvalid_o && tx_tready_i) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected byte", {22'd0, tx_csum_o, tx_tlast_o, tx_tdata_o}, 32'd0);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk({tx_csum_o, tx_tlast_o, tx_tdata_o} == e, "R5 R7 R9 byte",
            {22'd0, tx_csum_o, tx_tlast_o, tx_tdata_o}, {22'd0, e});
      end
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_tready_i = lfsr[0] | lfsr[3];
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  task automatic put_byte(input int a, input logic [7:0] v);
    wmem[a >> 2][8*(a & 3) +: 8] = v;
  endtask

  // one descriptor; its bytes are pushed when push is set
  task automatic desc(input int da, input bit own, input int len, input bit eof,
                      input logic [1:0] cs, input int bufa, input int nxt,
                      input logic [7:0] seed, input bit push);
    wmem[da >> 2]       = {own, 31'd0};
    wmem[(da >> 2) + 1] = {1'b0, eof, 1'b1, cs, 16'd0, len[10:0]};
    wmem[(da >> 2) + 2] = bufa;
    wmem[(da >> 2) + 3] = nxt;
    for (int k = 0; k < len; k++) begin
      put_byte(bufa + k, seed + 8'(k));
      if (push) exp_q.push_back({2'b00, seed + 8'(k)});
    end
  endtask

  task automatic close_frame(input int fs, input bit cs);
    for (int i = fs; i < exp_q.size(); i++) exp_q[i][9] = cs;
    exp_q[exp_q.size() - 1][8] = 1'b1;
  endtask

  task automatic load_list(input int a);
    list_wr_i = 1'b1; list_addr_i = a;
    @(negedge clk);
    list_wr_i = 1'b0;
  endtask

  task automatic ctl_write(input logic [31:0] v);
    ctl_wr_i = 1'b1; ctl_wdata_i = v;
    @(negedge clk);
    ctl_wr_i = 1'b0;
  endtask

  task automatic clear_done;
    done_clr_i = 1'b1;
    @(negedge clk);
    done_clr_i = 1'b0;
  endtask

  task automatic wait_idle;
    repeat (2) @(negedge clk);
    while (busy_o) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int fs;
    for (int i = 0; i < 4096; i++) wmem[i] = 32'd0;
    lfsr = 16'hACE1;
    tx_tready_i = 1'b1;
    mem_ack_i = 1'b0; mem_rdata_i = 32'd0;
    list_wr_i = 1'b0; list_addr_i = 32'd0;
    ctl_wr_i = 1'b0; ctl_wdata_i = 32'd0; done_clr_i = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({busy_o, done_o, xfer_start_o, mem_req_o, tx_tvalid_o} == 5'b0, "R1 reset outputs",
        {27'd0, busy_o, done_o, xfer_start_o, mem_req_o, tx_tvalid_o}, 32'd0);
    chk(cur_desc_o == 0, "R1 reset pointer", cur_desc_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: start bit without enable does nothing
    desc(32'h100, 1'b1, 10, 1'b1, 2'b00, 32'h1000, 32'h140, 8'h30, 1'b0);
    load_list(32'h100);
    chk(cur_desc_o == 32'h100, "R2 pointer load", cur_desc_o, 32'h100);
    ctl_write(32'h8000_0000);
    repeat (8) @(negedge clk);
    chk(busy_o == 1'b0, "R3 no walk without enable", {31'd0, busy_o}, 32'd0);
    chk(wmem[32'h100 >> 2] == 32'h8000_0000, "R3 descriptor untouched", wmem[32'h100 >> 2], 32'h8000_0000);
    chk(xfer_start_o == 1'b1, "R3 start bit stored", {31'd0, xfer_start_o}, 32'd1);

    // single-fragment frame
    fs = exp_q.size();
    desc(32'h100, 1'b1, 10, 1'b1, 2'b00, 32'h1000, 32'h140, 8'h30, 1'b1);
    close_frame(fs, 1'b0);
    ctl_write(32'hC000_0000);
    wait_idle();
    chk(wmem[32'h100 >> 2] == 32'h0, "R6 ownership returned", wmem[32'h100 >> 2], 32'h0);
    chk(cur_desc_o == 32'h140, "R4 stop at unowned", cur_desc_o, 32'h140);
    chk(done_o == 1'b1, "R11 done set", {31'd0, done_o}, 32'd1);
    chk(xfer_start_o == 1'b0, "R11 start cleared", {31'd0, xfer_start_o}, 32'd0);
    chk(exp_q.size() == 0, "R7 frame fully emitted", exp_q.size(), 32'd0);
    clear_done();
    chk(done_o == 1'b0, "R11 done cleared", {31'd0, done_o}, 32'd0);

    // three frames: multi-fragment with empty fragment, checksum codes
    fs = exp_q.size();
    desc(32'h200, 1'b1, 5, 1'b0, 2'b00, 32'h1100, 32'h210, 8'h50, 1'b1);
    desc(32'h210, 1'b1, 0, 1'b0, 2'b00, 32'h1200, 32'h220, 8'h00, 1'b1);
    desc(32'h220, 1'b1, 7, 1'b1, 2'b01, 32'h1300, 32'h230, 8'h90, 1'b1);
    close_frame(fs, 1'b1);
    fs = exp_q.size();
    desc(32'h230, 1'b1, 3, 1'b1, 2'b10, 32'h1400, 32'h240, 8'hC0, 1'b1);
    close_frame(fs, 1'b1);
    fs = exp_q.size();
    desc(32'h240, 1'b1, 1, 1'b1, 2'b00, 32'h1500, 32'h250, 8'hEE, 1'b1);
    close_frame(fs, 1'b0);
    load_list(32'h200);
    ctl_write(32'hC000_0000);
    wait_idle();
    for (int d = 0; d < 5; d++)
      chk(wmem[(32'h200 >> 2) + 4*d] == 32'h0, "R6 handback chain", wmem[(32'h200 >> 2) + 4*d], 32'h0);
    chk(cur_desc_o == 32'h250, "R4 chain end", cur_desc_o, 32'h250);
    chk(exp_q.size() == 0, "R7 all frames emitted", exp_q.size(), 32'd0);
    clear_done();

    // no owned descriptor: no completion
    load_list(32'h250);
    ctl_write(32'hC000_0000);
    wait_idle();
    chk(done_o == 1'b0, "R11 no frame no done", {31'd0, done_o}, 32'd0);
    chk(xfer_start_o == 1'b1, "R11 start kept", {31'd0, xfer_start_o}, 32'd1);
    chk(cur_desc_o == 32'h250, "R4 pointer kept", cur_desc_o, 32'h250);

    // overflow: 2000 + 100 > 2048
    desc(32'h300, 1'b1, 2000, 1'b0, 2'b00, 32'h2000, 32'h310, 8'h11, 1'b0);
    desc(32'h310, 1'b1, 100, 1'b1, 2'b00, 32'h2800, 32'h320, 8'h22, 1'b0);
    load_list(32'h300);
    ctl_write(32'hC000_0000);
    wait_idle();
    chk(wmem[32'h300 >> 2] == 32'h0, "R10 first fragment handed back", wmem[32'h300 >> 2], 32'h0);
    chk(wmem[32'h310 >> 2] == 32'h8000_4000, "R10 length error status", wmem[32'h310 >> 2], 32'h8000_4000);
    chk(cur_desc_o == 32'h310, "R10 stop at rejected", cur_desc_o, 32'h310);
    chk(done_o == 1'b0, "R10 no frame emitted", {31'd0, done_o}, 32'd0);

    // exactly 2048 bytes, pointer write during walk ignored
    fs = exp_q.size();
    desc(32'h400, 1'b1, 2047, 1'b0, 2'b00, 32'h2000, 32'h410, 8'h07, 1'b1);
    desc(32'h410, 1'b1, 1, 1'b1, 2'b11, 32'h3000, 32'h420, 8'hA5, 1'b1);
    close_frame(fs, 1'b1);
    load_list(32'h400);
    ctl_write(32'hC000_0000);
    repeat (40) @(negedge clk);
    load_list(32'h3800);
    wait_idle();
    chk(cur_desc_o == 32'h420, "R2 write while busy ignored", cur_desc_o, 32'h420);
    chk(wmem[32'h410 >> 2] == 32'h0, "R10 2048 accepted", wmem[32'h410 >> 2], 32'h0);
    chk(done_o == 1'b1, "R11 done after boundary frame", {31'd0, done_o}, 32'd1);
    chk(exp_q.size() == 0, "R10 boundary frame emitted", exp_q.size(), 32'd0);

    report();
  end

endmodule